// File: doc/BRIEF.md
# Segmented Address Translator

This block converts a logical address, given as a 16-bit segment value and a 16-bit offset, into a 32-bit linear address. It has two ways of forming the result. In real mode the segment is scaled by sixteen and added to the offset. The sum is kept to 20 bits, so real mode never reaches beyond the first megabyte. In protected mode the low bits of the segment select one entry of a small on-chip table of segment base addresses. The offset is then added to that base.

A mode input chooses the scheme for each request. The block comes out of reset in real mode, with every table entry cleared to zero. Software-visible control logic elsewhere fills the table through a separate write port, which takes an entry index and a 32-bit base. Each request carries a valid flag. The result appears on a registered output one clock later, together with its own valid flag.

Top module: `seg_xlate`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and lin_addr_o is 0.
- R2: When prot_mode_i is 0 (real mode), the result is (seg_i * 16 + off_i) modulo 2^20, zero-extended to 32 bits. For example, 1200:F445 gives 0x21445 and FFFF:FFFF wraps to 0x0FFEF.
- R3: In real mode, bits 31..20 of lin_addr_o are always 0.
- R4: When prot_mode_i is 1 (protected mode), the result is (table[seg_i[3:0]] + off_i) modulo 2^32. Bits 15..4 of seg_i have no effect.
- R5: valid_o equals the valid_i of the previous clock. A result presented with valid_i high in one cycle appears on lin_addr_o in the next cycle.
- R6: Reset clears all 16 table entries to zero, so a protected-mode translation before any write returns the offset alone.
- R7: When dt_we_i is high, dt_data_i is stored into entry dt_idx_i at the clock edge. A translation in that same cycle that selects the same entry uses the old base. Translations from the next cycle on use the new base.
- R8: When valid_i is low, lin_addr_o keeps its previous value, whatever the other request inputs do.
- R9: Different real-mode segment:offset pairs that describe the same location give the same result. For example, 2222:3333 and 2000:5553 both give 0x25553.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| prot_mode_i | input | 1 | 0 = real mode, 1 = protected mode |
| seg_i | input | 16 | Segment value |
| off_i | input | 16 | Offset within the segment |
| dt_we_i | input | 1 | Table write enable |
| dt_idx_i | input | 4 | Table entry to write |
| dt_data_i | input | 32 | Base address to write |
| valid_o | output | 1 | Result valid, one clock after valid_i |
| lin_addr_o | output | 32 | Registered linear address |

## Verification
A table write and a protected-mode lookup can land in the same cycle, and both can address the same entry. The bench provokes this by raising dt_we_i for entry 7 in the same cycle as a protected request whose segment selects entry 7. It then repeats the request in the following cycle. The scoreboard expects the old base in the first result and the new base in the second, because its model applies the write only after computing that cycle's expected value.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned SEG_W  = 16;
  localparam int unsigned OFF_W  = 16;
  localparam int unsigned LIN_W  = 32;
  localparam int unsigned REAL_W = 20;
  localparam int unsigned SEL_W  = 4;

  typedef enum logic {
    MODE_REAL = 1'b0,
    MODE_PROT = 1'b1
  } xlate_mode_e;
endpackage

// File: rtl/seg_real_sum.sv
module seg_real_sum #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned REAL_W = 20,
  parameter int unsigned LIN_W  = 32
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [LIN_W-1:0] lin_o
);
  localparam int unsigned SHIFT = REAL_W - SEG_W;
  localparam int unsigned PAD   = LIN_W - REAL_W;

  logic [REAL_W-1:0] sum;

  // carry out of the top bit is dropped: wraps inside the real-mode window
  assign sum   = {seg_i, {SHIFT{1'b0}}} + REAL_W'(off_i);
  assign lin_o = {{PAD{1'b0}}, sum};
endmodule

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned BASE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  wr_idx_i,
  input  logic [BASE_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_idx_i,
  output logic [BASE_W-1:0] rd_base_o
);
  localparam int unsigned ENTRIES = 1 << SEL_W;

  logic [BASE_W-1:0] entry_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_q[g] <= '0;
      end else if (we_i && (wr_idx_i == SEL_W'(g))) begin
        entry_q[g] <= wr_data_i;
      end
    end
  end

  // read sees pre-write contents in the write cycle
  assign rd_base_o = entry_q[rd_idx_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> entry_q[$past(wr_idx_i)] == $past(wr_data_i)); // R7
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned P_SEG_W  = SEG_W,
  parameter int unsigned P_OFF_W  = OFF_W,
  parameter int unsigned P_LIN_W  = LIN_W,
  parameter int unsigned P_REAL_W = REAL_W,
  parameter int unsigned P_SEL_W  = SEL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                prot_mode_i,
  input  logic [P_SEG_W-1:0]  seg_i,
  input  logic [P_OFF_W-1:0]  off_i,
  input  logic                dt_we_i,
  input  logic [P_SEL_W-1:0]  dt_idx_i,
  input  logic [P_LIN_W-1:0]  dt_data_i,
  output logic                valid_o,
  output logic [P_LIN_W-1:0]  lin_addr_o
);
  xlate_mode_e        mode;
  logic [P_LIN_W-1:0] real_lin;
  logic [P_LIN_W-1:0] prot_base;
  logic [P_LIN_W-1:0] prot_lin;
  logic [P_LIN_W-1:0] lin_d;
  logic [P_LIN_W-1:0] lin_q;
  logic               valid_q;
  logic               unused_seg_hi;

  assign mode          = xlate_mode_e'(prot_mode_i);
  assign unused_seg_hi = ^seg_i[P_SEG_W-1:P_SEL_W];

  seg_real_sum #(
    .SEG_W (P_SEG_W),
    .OFF_W (P_OFF_W),
    .REAL_W(P_REAL_W),
    .LIN_W (P_LIN_W)
  ) i_real (
    .seg_i(seg_i),
    .off_i(off_i),
    .lin_o(real_lin)
  );

  seg_desc_table #(
    .SEL_W (P_SEL_W),
    .BASE_W(P_LIN_W)
  ) i_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (dt_we_i),
    .wr_idx_i (dt_idx_i),
    .wr_data_i(dt_data_i),
    .rd_idx_i (seg_i[P_SEL_W-1:0]),
    .rd_base_o(prot_base)
  );

  assign prot_lin = prot_base + P_LIN_W'(off_i);

  always_comb begin
    unique case (mode)
      MODE_PROT: lin_d = prot_lin;
      default:   lin_d = real_lin;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      lin_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) lin_q <= lin_d;
    end
  end

  assign valid_o    = valid_q;
  assign lin_addr_o = lin_q;

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && lin_addr_o == '0)); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R5
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R5
  AST_REAL_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !prot_mode_i) |=> lin_addr_o[P_LIN_W-1:P_REAL_W] == '0); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(lin_addr_o)); // R8
endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        prot_mode_i = 1'b0;
  logic [15:0] seg_i = '0;
  logic [15:0] off_i = '0;
  logic        dt_we_i = 1'b0;
  logic [3:0]  dt_idx_i = '0;
  logic [31:0] dt_data_i = '0;
  logic        valid_o;
  logic [31:0] lin_addr_o;

  int errors = 0;
  int checks = 0;

  logic [31:0] model_tbl [16];
  logic [31:0] model_last = '0;
  logic        exp_v_q [$];
  logic [31:0] exp_a_q [$];
  string       tag_q [$];

  always #2 clk_i = ~clk_i;

  seg_xlate i_seg_xlate (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .prot_mode_i(prot_mode_i),
    .seg_i(seg_i), .off_i(off_i), .dt_we_i(dt_we_i), .dt_idx_i(dt_idx_i),
    .dt_data_i(dt_data_i), .valid_o(valid_o), .lin_addr_o(lin_addr_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply inputs at negedge, push the expected output of the next edge
  task automatic step(string tag, logic v, logic pm, logic [15:0] s, logic [15:0] o,
                      logic we = 1'b0, logic [3:0] wi = '0, logic [31:0] wd = '0);
    logic [31:0] e;
    @(negedge clk_i);
    valid_i = v; prot_mode_i = pm; seg_i = s; off_i = o;
    dt_we_i = we; dt_idx_i = wi; dt_data_i = wd;
    if (pm) e = model_tbl[s[3:0]] + {16'h0, o};
    else    e = {12'h0, (({s, 4'h0}) + {4'h0, o})};
    if (v) model_last = e;
    exp_v_q.push_back(v);
    exp_a_q.push_back(model_last);
    tag_q.push_back(tag);
    if (we) model_tbl[wi] = wd;
  endtask

  // monitor: compare after each edge
  always @(posedge clk_i) begin
    if (rst_ni) begin
      #1;
      if (exp_v_q.size() > 0) begin
        logic        ev;
        logic [31:0] ea;
        string       t;
        ev = exp_v_q.pop_front();
        ea = exp_a_q.pop_front();
        t  = tag_q.pop_front();
        check({t, " valid"}, {31'h0, valid_o}, {31'h0, ev});
        check({t, " addr"}, lin_addr_o, ea);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model_tbl[i] = '0;
    // R1: drive a valid request during reset, outputs must stay cleared
    valid_i = 1'b1; seg_i = 16'h1234; off_i = 16'h5678;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 valid_o in reset", {31'h0, valid_o}, 32'h0);
    check("R1 lin_addr_o in reset", lin_addr_o, 32'h0);
    valid_i = 1'b0;
    rst_ni = 1'b1;

    // R6: table cleared, protected gives offset
    step("R6 cleared entry 5", 1, 1, 16'h0005, 16'h1234);
    step("R6 cleared entry 15", 1, 1, 16'hFFFF, 16'hFFFF);
    // R2 real mode
    step("R2 real 1200:F445", 1, 0, 16'h1200, 16'hF445);
    step("R2 real wrap FFFF:FFFF", 1, 0, 16'hFFFF, 16'hFFFF);
    step("R3 real top zero", 1, 0, 16'hF000, 16'h0010);
    // R9 aliases
    step("R9 alias 2222:3333", 1, 0, 16'h2222, 16'h3333);
    step("R9 alias 2000:5553", 1, 0, 16'h2000, 16'h5553);
    // R4 protected with writes
    step("R4 write e3", 0, 0, 16'h0, 16'h0, 1, 4'd3, 32'h0040_0000);
    step("R4 write e15", 0, 0, 16'h0, 16'h0, 1, 4'd15, 32'hFFFF_FF00);
    step("R4 prot e3 high seg bits", 1, 1, 16'hAB03, 16'h0010);
    step("R4 prot e3 plain", 1, 1, 16'h0003, 16'h0010);
    step("R4 prot e15 wrap", 1, 1, 16'h000F, 16'h0200);
    step("R4 real after write", 1, 0, 16'h0003, 16'h0010);
    // R7: same-cycle write and lookup of entry 7
    step("R7 same cycle old base", 1, 1, 16'h0007, 16'h0044, 1, 4'd7, 32'h0000_1000);
    step("R7 next cycle new base", 1, 1, 16'h0007, 16'h0044);
    // R8: idle cycles with busy inputs hold the address
    step("R8 hold a", 0, 1, 16'h0003, 16'hFFFF);
    step("R8 hold b", 0, 0, 16'hFFFF, 16'h1111);
    // R5: valid toggling
    step("R5 valid on", 1, 0, 16'h0001, 16'h0001);
    step("R5 valid off", 0, 0, 16'h0002, 16'h0002);
    step("R5 valid on again", 1, 1, 16'h0007, 16'h0001);
    // mixed sweep
    for (int k = 0; k < 40; k++) begin
      logic [15:0] s;
      logic [15:0] o;
      s = 16'(k * 16'h1357 + 16'h0F0F);
      o = 16'(k * 16'h2468 + 16'hF00F);
      step("R2 R4 R5 sweep", (k % 5) != 0, k[0], s, o,
           (k % 7) == 0, 4'(k), 32'(k * 32'h0101_0101));
    end
    step("tail", 0, 0, 16'h0, 16'h0);
    @(negedge clk_i);
    @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule